// File: doc/BRIEF.md
# Half-Bridge Clock Generator with Dead-Time

This block is a digital oscillator for a half-bridge. It drives two complementary gate enables, `gate_lo` and `gate_hi`. An internal cycle counter runs at twice the switching rate. Each internal cycle has two phases. In the charge phase one output is high, and the length of that phase comes from the frequency request. In the blanking phase both outputs are low, and its length is the programmed dead-time. A steering bit flips at the end of every internal cycle, so the charge phases go to the lower and upper outputs in turn. The dead-time is the same whatever the period, which means the switching frequency does not follow the command linearly.

All lengths are counts of the system clock. The feedback command maps onto a charge length. Below a dead-zone threshold it gives the longest length, which is the minimum frequency. Above the threshold each command step shortens the length by a fixed power of two, down to the shortest length, which is the maximum frequency. A soft-start ramp runs beside the feedback path. It begins at the shortest length and grows by one count every internal cycle until it reaches the longest length. The length used for a cycle is the shorter of the ramp and the feedback values, so feedback takes over as soon as it asks for a higher frequency than the ramp.

Removing `enable` blanks both outputs in the same cycle. Removing `enable` or pulsing `ss_restart` sends the block back to its idle state. The next start begins with the lower output and runs a fresh soft-start.

Top module: `hb_clkgen`

## Requirements
- R1: `gate_lo` and `gate_hi` are never high together. Charge phases go to `gate_lo` and `gate_hi` in strict alternation.
- R2: Each charge pulse lasts exactly the length chosen at the start of that pulse. A command change during a pulse does not alter it.
- R3: After every pulse both outputs stay low for exactly `dead_len` clocks before the next pulse starts, whatever the period.
- R4: The feedback length depends on `fb_cmd`. When `fb_cmd <= DZ_CMD` it is `len_slow`. Above that, let r = (`fb_cmd` - `DZ_CMD`) << `GAIN_SH`. The length is `len_slow - r`, or `len_fast` when r >= `len_slow - len_fast`.
- R5: After a start, the first two pulses last `len_fast` clocks. After that, the ramp lengthens each pulse by one clock until it reaches `len_slow`.
- R6: The length used for a pulse is the smaller of the ramp value and the feedback value.
- R7: On every start, whether after enable or after `ss_restart`, the first pulse is on `gate_lo`.
- R8: While `enable` is low both outputs are low in the same cycle. On re-enable the block restarts with `gate_lo` and a fresh ramp.
- R9: After reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request; low blanks outputs immediately |
| ss_restart | input | 1 | One-cycle request to restart with soft-start |
| fb_cmd | input | CMD_W | Feedback command; higher value gives higher frequency |
| len_slow | input | CNT_W | Charge length at minimum frequency, in clocks |
| len_fast | input | CNT_W | Charge length at maximum frequency, in clocks |
| dead_len | input | CNT_W | Blanking length per internal cycle, in clocks |
| gate_lo | output | 1 | Lower switch gate enable |
| gate_hi | output | 1 | Upper switch gate enable |

## Verification
A reference model compares both outputs on every clock. The stimulus covers these cases:
- The feedback command is held in the dead zone, at saturation and at a mid value. This separates the three branches of the feedback mapping, and a wrong shift or a wrong clamp shows up as a wrong pulse width.
- A restart with a mid-range command lets the ramp climb until feedback takes over. This shows whether the shorter-length selection is correct, and whether the ramp steps once per internal cycle rather than once per switching period.
- Enable is dropped in the middle of a pulse, and a restart is requested. These show whether blanking is immediate and whether the lower output leads every new start.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
   typedef enum logic {
      PH_CHG = 1'b0,
      PH_DIS = 1'b1
   } hbc_phase_e;
endpackage

// File: rtl/hbc_fb_map.sv
module hbc_fb_map #(
   parameter int CNT_W   = 10,
   parameter int CMD_W   = 8,
   parameter int DZ_CMD  = 32,
   parameter int GAIN_SH = 1
) (
   input  logic [CMD_W-1:0] cmd,
   input  logic [CNT_W-1:0] slow_len,
   input  logic [CNT_W-1:0] fast_len,
   output logic [CNT_W-1:0] fb_len
);
   localparam int RW = (((CMD_W + GAIN_SH) > CNT_W) ? (CMD_W + GAIN_SH) : CNT_W) + 1;
   localparam logic [CMD_W-1:0] DZ_V = CMD_W'(DZ_CMD);

   logic [RW-1:0] red;
   logic [RW-1:0] span;

   always_comb begin
      red    = RW'(cmd - DZ_V) << GAIN_SH;
      span   = RW'(slow_len) - RW'(fast_len);
      fb_len = slow_len;
      if (cmd > DZ_V) begin
         if ((slow_len <= fast_len) || (red >= span)) fb_len = fast_len;
         else                                         fb_len = slow_len - CNT_W'(red);
      end
   end
endmodule

// File: rtl/hbc_ss_ramp.sv
module hbc_ss_ramp #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [CNT_W-1:0] fast_len,
   input  logic [CNT_W-1:0] slow_len,
   output logic [CNT_W-1:0] ss_len
);
   logic [CNT_W-1:0] ss_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ss_q <= '0;
      else if (clear)                      ss_q <= fast_len;
      else if (step && (ss_q < slow_len))  ss_q <= ss_q + 1'b1;
   end

   assign ss_len = ss_q;
endmodule

// File: rtl/hbc_osc.sv
module hbc_osc
   import hbc_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             restart,
   input  logic [CNT_W-1:0] next_len,
   input  logic [CNT_W-1:0] dead_len,
   output logic             running,
   output logic             cyc_end,
   output logic [1:0]       gates
);
   logic             run_q;
   hbc_phase_e       ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;
   logic             steer_q;
   logic [CNT_W-1:0] len_e;
   logic [CNT_W-1:0] dead_e;
   logic             chg_end;

   assign len_e   = (next_len == '0) ? CNT_W'(1) : next_len;
   assign dead_e  = (dead_len == '0) ? CNT_W'(1) : dead_len;
   assign chg_end = run_q && (ph_q == PH_CHG) && (cnt_q >= len_q);
   assign cyc_end = run_q && (ph_q == PH_DIS) && (cnt_q >= dead_e);
   assign running = run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         ph_q    <= PH_CHG;
         cnt_q   <= '0;
         len_q   <= CNT_W'(1);
         steer_q <= 1'b0;
      end else if (!enable || restart) begin
         run_q   <= 1'b0;
         ph_q    <= PH_CHG;
         cnt_q   <= '0;
         steer_q <= 1'b0;
      end else if (!run_q) begin
         run_q <= 1'b1;
         ph_q  <= PH_CHG;
         cnt_q <= CNT_W'(1);
         len_q <= len_e;
      end else if (chg_end) begin
         ph_q  <= PH_DIS;
         cnt_q <= CNT_W'(1);
      end else if (cyc_end) begin
         ph_q    <= PH_CHG;
         cnt_q   <= CNT_W'(1);
         len_q   <= len_e;
         steer_q <= ~steer_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_leg
      assign gates[g] = enable && run_q && (ph_q == PH_CHG) && (steer_q == 1'(g));
   end
endmodule

// File: rtl/hb_clkgen.sv
module hb_clkgen #(
   parameter int CNT_W   = 10,
   parameter int CMD_W   = 8,
   parameter int DZ_CMD  = 32,
   parameter int GAIN_SH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             ss_restart,
   input  logic [CMD_W-1:0] fb_cmd,
   input  logic [CNT_W-1:0] len_slow,
   input  logic [CNT_W-1:0] len_fast,
   input  logic [CNT_W-1:0] dead_len,
   output logic             gate_lo,
   output logic             gate_hi
);
   if (CNT_W < 2)                   $error("hb_clkgen: CNT_W must be at least 2");
   if (CMD_W < 1)                   $error("hb_clkgen: CMD_W must be at least 1");
   if (DZ_CMD >= (1 << CMD_W))      $error("hb_clkgen: DZ_CMD exceeds command range");
   if (GAIN_SH < 0 || GAIN_SH > 8)  $error("hb_clkgen: GAIN_SH out of range");

   logic [CNT_W-1:0] fb_len;
   logic [CNT_W-1:0] ss_len;
   logic [CNT_W-1:0] ramp_len;
   logic [CNT_W-1:0] use_len;
   logic             running;
   logic             cyc_end;
   logic [1:0]       gates;

   hbc_fb_map #(.CNT_W(CNT_W), .CMD_W(CMD_W), .DZ_CMD(DZ_CMD), .GAIN_SH(GAIN_SH)) u_map (
      .cmd(fb_cmd), .slow_len(len_slow), .fast_len(len_fast), .fb_len(fb_len)
   );

   hbc_ss_ramp #(.CNT_W(CNT_W)) u_ramp (
      .clk(clk), .rst_n(rst_n), .clear(!running), .step(cyc_end),
      .fast_len(len_fast), .slow_len(len_slow), .ss_len(ss_len)
   );

   assign ramp_len = running ? ss_len : len_fast;
   assign use_len  = (ramp_len < fb_len) ? ramp_len : fb_len;

   hbc_osc #(.CNT_W(CNT_W)) u_osc (
      .clk(clk), .rst_n(rst_n), .enable(enable), .restart(ss_restart),
      .next_len(use_len), .dead_len(dead_len),
      .running(running), .cyc_end(cyc_end), .gates(gates)
   );

   assign gate_lo = gates[0];
   assign gate_hi = gates[1];
endmodule

// File: rtl/hb_clkgen_chk.sv
module hb_clkgen_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic ss_restart,
   input logic gate_lo,
   input logic gate_hi
);
   logic lo_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    lo_seen <= 1'b0;
      else if (!enable || ss_restart) lo_seen <= 1'b0;
      else if (gate_lo)              lo_seen <= 1'b1;
   end

   AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_lo && gate_hi)); // R1
   AST_DISABLE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!gate_lo && !gate_hi)); // R8
   AST_GAP_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_lo) |-> !gate_hi); // R3
   AST_GAP_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_hi) |-> !gate_lo); // R3
   AST_LOWER_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi) |-> lo_seen); // R7
endmodule

bind hb_clkgen hb_clkgen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .ss_restart(ss_restart),
   .gate_lo(gate_lo), .gate_hi(gate_hi)
);

// File: tb/sim_hb_clkgen.sv
`timescale 1ns/1ps
module sim_hb_clkgen;
   localparam int CNT_W = 10;
   localparam int CMD_W = 8;
   localparam int DZ    = 32;
   localparam int SH    = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic rs = 1'b0;
   logic [CMD_W-1:0] cmd = '0;
   logic [CNT_W-1:0] slow = 10'd40;
   logic [CNT_W-1:0] fast = 10'd10;
   logic [CNT_W-1:0] dead = 10'd3;
   logic lo, hi;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hb_clkgen #(.CNT_W(CNT_W), .CMD_W(CMD_W), .DZ_CMD(DZ), .GAIN_SH(SH)) u0 (
      .clk(clk), .rst_n(rst_n), .enable(en), .ss_restart(rs), .fb_cmd(cmd),
      .len_slow(slow), .len_fast(fast), .dead_len(dead), .gate_lo(lo), .gate_hi(hi)
   );

   function automatic int fb_of(int c);
      int r;
      if (c <= DZ) return int'(slow);
      r = (c - DZ) << SH;
      if (r >= int'(slow) - int'(fast)) return int'(fast);
      return int'(slow) - r;
   endfunction

   function automatic int imin(int a, int b);
      return (a < b) ? a : b;
   endfunction

   // behavioural reference: timeline of an internal cycle
   int m_run = 0, m_blank = 0, m_pos = 0, m_side = 0, m_len = 1, m_ramp = 0;

   always @(posedge clk) begin
      if (!rst_n || !en || rs) begin
         m_run = 0; m_blank = 0; m_pos = 0; m_side = 0;
      end else if (m_run == 0) begin
         m_run = 1; m_blank = 0; m_pos = 1; m_ramp = int'(fast);
         m_len = imin(int'(fast), fb_of(int'(cmd)));
      end else if (m_blank == 0) begin
         if (m_pos >= m_len) begin m_blank = 1; m_pos = 1; end
         else m_pos++;
      end else begin
         if (m_pos >= int'(dead)) begin
            m_blank = 0; m_pos = 1; m_side = 1 - m_side;
            m_len = imin(m_ramp, fb_of(int'(cmd)));
            if (m_ramp < int'(slow)) m_ramp++;
         end else m_pos++;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit elo, ehi;
         elo = en && m_run == 1 && m_blank == 0 && m_side == 0;
         ehi = en && m_run == 1 && m_blank == 0 && m_side == 1;
         tests++;
         if (lo !== elo || hi !== ehi) begin
            fails++;
            if (!en)          $display("FAIL R8 outputs lo/hi=%b%b expected %b%b", lo, hi, elo, ehi);
            else if (m_blank) $display("FAIL R3 outputs lo/hi=%b%b expected %b%b", lo, hi, elo, ehi);
            else              $display("FAIL R2 outputs lo/hi=%b%b expected %b%b", lo, hi, elo, ehi);
         end
      end
   end

   task automatic check(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // called just after a negedge; returns side (0 lo, 1 hi), high length and gap
   task automatic next_pulse(output int side, output int len, output int gap);
      gap = 0;
      while (!lo && !hi) begin gap++; @(negedge clk); end
      side = hi ? 1 : 0;
      len = 0;
      while ((side == 0) ? lo : hi) begin len++; @(negedge clk); end
   endtask

   task automatic set_in(logic e, logic [CMD_W-1:0] c);
      @(negedge clk); #1;
      en = e; cmd = c;
   endtask

   initial begin
      int s, l, g;
      repeat (3) @(negedge clk);
      check("R9 reset lo", int'(lo), 0);
      check("R9 reset hi", int'(hi), 0);
      #1 rst_n = 1'b1;

      // start in dead zone: ramp alone sets the length
      set_in(1'b1, 8'd0);
      @(negedge clk);
      next_pulse(s, l, g);
      check("R7 first side lower", s, 0);
      check("R5 first pulse fast", l, 10);
      next_pulse(s, l, g);
      check("R1 second side upper", s, 1);
      check("R5 second pulse fast", l, 10);
      check("R3 gap lo to hi", g, 3);
      next_pulse(s, l, g);
      check("R5 third pulse +1", l, 11);
      check("R3 gap hi to lo", g, 3);
      next_pulse(s, l, g);
      check("R5 fourth pulse +2", l, 12);

      // ramp finished, dead zone gives the slow length
      repeat (1600) @(negedge clk);
      next_pulse(s, l, g);
      next_pulse(s, l, g);
      check("R4 dead zone length", l, 40);
      check("R3 gap at slow period", g, 3);

      // saturated command
      set_in(1'b1, 8'd255);
      @(negedge clk);
      next_pulse(s, l, g);
      next_pulse(s, l, g);
      next_pulse(s, l, g);
      check("R4 saturated length", l, 10);

      // mid command: 40 - (5<<1) = 30
      set_in(1'b1, 8'(DZ + 5));
      @(negedge clk);
      next_pulse(s, l, g);
      next_pulse(s, l, g);
      next_pulse(s, l, g);
      check("R4 linear length", l, 30);

      // command change during a pulse does not change it
      while (!lo && !hi) @(negedge clk);
      #1 cmd = 8'd255;
      @(negedge clk);
      l = 1;
      while (lo || hi) begin l++; @(negedge clk); end
      check("R2 pulse length held", l, 30);

      // restart with mid command: ramp then feedback takes over
      set_in(1'b1, 8'(DZ + 5));
      #1 rs = 1'b1;
      @(negedge clk); #1 rs = 1'b0;
      @(negedge clk);
      next_pulse(s, l, g);
      check("R7 restart lower first", s, 0);
      check("R6 restart ramp length", l, 10);
      repeat (1200) @(negedge clk);
      next_pulse(s, l, g);
      next_pulse(s, l, g);
      check("R6 feedback takeover", l, 30);

      // drop enable in the middle of a pulse
      while (!lo && !hi) @(negedge clk);
      @(negedge clk); #1 en = 1'b0;
      #1;
      check("R8 blank lo same cycle", int'(lo), 0);
      check("R8 blank hi same cycle", int'(hi), 0);
      repeat (5) @(negedge clk);
      #1 en = 1'b1;
      @(negedge clk);
      next_pulse(s, l, g);
      check("R8 re-enable lower first", s, 0);
      check("R8 re-enable ramp from fast", l, 10);

      repeat (20) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired, actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule